// File: doc/BRIEF.md
# Lockable Sticky Status Register Bank

This block holds a small set of configuration and status fields behind a plain register bus. The bus has an address, a write strobe with write data and per-byte enables, and a read strobe. Each field has an access policy fixed at elaboration time:

- constant read-only
- live hardware status
- read/write
- write-1-to-clear event bits
- hardware-updated volatile fields
- key bits

Any of these policies can also be sticky, meaning it survives a warm reset.

Key bits take away software write access from their target fields, but hardware can still update those targets. A key can itself be the target of another key, which forms a cascade. Every key is self-locking. Once it leaves its reset value it cannot be written again, so only a reset clears it. Writing its reset value back does not engage it. A warm reset clears every non-sticky field. A cold reset clears everything.

The bus is a control path and has no back-pressure. A write takes effect at the clock edge where the write strobe is high. A read strobe is accepted every cycle, and the read data register updates at that same edge.

Top module: `rsb_bank`

## Requirements
- R1: Register 1 bits [7:0] return the constant ID_VAL (default 0xC3) and bits [15:8] return the live `hw_status` input. Writes to these bits have no effect.
- R2: Register 1 bits [23:16] are event bits. A pulse on `evt_set` sets them. Writing 1 to a bit clears it, and writing 0 has no effect. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R3: Register 1 bits [31:24] (set by `sevt_set`) and register 2 bits [7:0] (set by `slk_set`) are sticky write-1-to-clear events. A warm reset leaves them unchanged and a cold reset clears them.
- R4: Register 0 bits [7:0] are read/write with reset value CFG_RST (default 0x5A). Only a bus write or a reset changes them.
- R5: Byte enable bit k gates write data bits [8k+7:8k]. Bits in lanes whose enable is low keep their value.
- R6: While key A (register 0 bit 16) is 1, software writes are ignored by register 0 bits [15:8] and by the write-1-to-clear action on register 2 bits [7:0]. Hardware sets on register 2 bits [7:0] still take effect.
- R7: While key B (register 0 bit 24) is 1, writes to key A are ignored.
- R8: Keys A, B and S reset to 0. Writing 0 to a key does not lock anything. Writing 1 locks both the key itself and its targets, and after that only a reset clears the key. Keys A and B clear on warm or cold reset. Key S (register 2 bit 24) clears only on cold reset.
- R9: Register 2 bits [15:8] are a volatile read/write field. A pulse on `vol_upd` loads `vol_val` and wins over a software write in the same cycle. While key S is 1, software writes to this field are ignored but hardware updates still apply.
- R10: Address 3 is unmapped. Reads of it return 0 and writes to it change nothing.
- R11: When `bus_rd` is high at a clock edge, `bus_rdata` takes the addressed register's value at that edge. Otherwise it holds its previous value. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset, clears all state |
| warm_rst_n | input | 1 | Asynchronous active-low warm reset, clears non-sticky state |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Per-byte write enables |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| hw_status | input | 8 | Live status shown in register 1 [15:8] |
| evt_set | input | 8 | Set pulses for register 1 [23:16] |
| sevt_set | input | 8 | Set pulses for register 1 [31:24] |
| slk_set | input | 8 | Set pulses for register 2 [7:0] |
| vol_upd | input | 1 | Hardware load strobe for register 2 [15:8] |
| vol_val | input | 8 | Hardware load value for register 2 [15:8] |

## Verification
The hardest case to reach from the ports is a sticky key that is still in force after a warm reset while its non-sticky neighbours have been cleared. The stimulus first sets key S and then a volatile value. It then asserts only the warm reset and checks three things: the volatile field has returned to 0, the key still reads 1, and a software write to the field is still refused. A cold reset follows to show the write becoming possible again. Two other races are reached by driving both sides in the same cycle: a hardware set against a write-1-to-clear on the same bit, and a hardware update against a software write.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [2:0] {
    POL_RO_CONST,
    POL_RO_LIVE,
    POL_RW,
    POL_W1C,
    POL_RWV,
    POL_KEY
  } pol_e;

  localparam int DATA_W   = 32;
  localparam int LANE_W   = 8;
  localparam int LANES    = DATA_W / LANE_W;
  localparam int NUM_REGS = 3;
  localparam int FLD_W    = 8;
endpackage

// File: rtl/rsb_field.sv
module rsb_field
  import rsb_pkg::*;
#(
  parameter int           W      = 8,
  parameter pol_e         POL    = POL_RW,
  parameter bit           STICKY = 1'b0,
  parameter logic [W-1:0] RST    = '0
) (
  input  logic         clk,
  input  logic         cold_rst_n,
  input  logic         warm_rst_n,
  input  logic [W-1:0] wr_bits,
  input  logic [W-1:0] wdata,
  input  logic         lock,
  input  logic [W-1:0] hw_set,
  input  logic         hw_upd,
  input  logic [W-1:0] hw_val,
  input  logic [W-1:0] hw_live,
  output logic [W-1:0] q
);
  logic unused_inputs;
  assign unused_inputs = ^{wr_bits, wdata, lock, hw_set, hw_upd, hw_val, hw_live};

  if (POL == POL_RO_CONST) begin : g_const
    assign q = RST;
  end else if (POL == POL_RO_LIVE) begin : g_live
    assign q = hw_live;
  end else begin : g_store
    logic [W-1:0] q_r;
    logic [W-1:0] nxt;
    logic         wr_ok;
    logic [W-1:0] merged;

    if (POL == POL_KEY) begin : g_selflock
      assign wr_ok = !lock && (q_r == RST);
    end else begin : g_extlock
      assign wr_ok = !lock;
    end

    assign merged = (q_r & ~wr_bits) | (wdata & wr_bits);

    always_comb begin
      nxt = q_r;
      case (POL)
        POL_RW, POL_KEY: if (wr_ok) nxt = merged;
        POL_W1C: nxt = (q_r & ~(wr_ok ? (wdata & wr_bits) : '0)) | hw_set;
        POL_RWV: begin
          if (hw_upd)     nxt = hw_val;
          else if (wr_ok) nxt = merged;
        end
        default: nxt = q_r;
      endcase
    end

    if (STICKY) begin : g_sticky
      always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) q_r <= RST;
        else             q_r <= nxt;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge cold_rst_n or negedge warm_rst_n) begin
        if (!cold_rst_n || !warm_rst_n) q_r <= RST;
        else                            q_r <= nxt;
      end
    end

    assign q = q_r;
  end
endmodule

// File: rtl/rsb_decode.sv
module rsb_decode
  import rsb_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic                               bus_wr,
  input  logic [LANES-1:0]                   bus_be,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    wr_bits
);
  logic [DATA_W-1:0] lane_mask;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{bus_be[l]}};
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign wr_bits[r] = (bus_wr && bus_addr == ADDR_W'(r)) ? lane_mask : '0;
  end
endmodule

// File: rtl/rsb_rdmux.sv
module rsb_rdmux
  import rsb_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                            clk,
  input  logic                            cold_rst_n,
  input  logic                            warm_rst_n,
  input  logic                            bus_rd,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  output logic [DATA_W-1:0]               bus_rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (bus_addr == ADDR_W'(r)) sel = regs[r];
    end
  end

  always_ff @(posedge clk or negedge cold_rst_n or negedge warm_rst_n) begin
    if (!cold_rst_n || !warm_rst_n) bus_rdata <= '0;
    else if (bus_rd)                bus_rdata <= sel;
  end
endmodule

// File: rtl/rsb_bank.sv
module rsb_bank
  import rsb_pkg::*;
#(
  parameter int               ADDR_W  = 2,
  parameter logic [FLD_W-1:0] ID_VAL  = 8'hC3,
  parameter logic [FLD_W-1:0] CFG_RST = 8'h5A
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        hw_status,
  input  logic [7:0]        evt_set,
  input  logic [7:0]        sevt_set,
  input  logic [7:0]        slk_set,
  input  logic              vol_upd,
  input  logic [7:0]        vol_val
);
  localparam logic [FLD_W-1:0] ZF = '0;

  logic [NUM_REGS-1:0][DATA_W-1:0] wr_bits;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  logic [FLD_W-1:0] cfg_q, cfglk_q, id_q, live_q, evt_q, sevt_q, slk_q, vol_q;
  logic             key_a_q, key_b_q, key_s_q;

  rsb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_be   (bus_be),
    .wr_bits  (wr_bits)
  );

  // Register 0: configuration and lock keys
  rsb_field #(.W(FLD_W), .POL(POL_RW), .STICKY(1'b0), .RST(CFG_RST)) u_cfg (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .wr_bits(wr_bits[0][7:0]), .wdata(bus_wdata[7:0]), .lock(1'b0),
    .hw_set(ZF), .hw_upd(1'b0), .hw_val(ZF), .hw_live(ZF), .q(cfg_q));

  rsb_field #(.W(FLD_W), .POL(POL_RW), .STICKY(1'b0), .RST(8'h00)) u_cfglk (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .wr_bits(wr_bits[0][15:8]), .wdata(bus_wdata[15:8]), .lock(key_a_q),
    .hw_set(ZF), .hw_upd(1'b0), .hw_val(ZF), .hw_live(ZF), .q(cfglk_q));

  rsb_field #(.W(1), .POL(POL_KEY), .STICKY(1'b0), .RST(1'b0)) u_key_a (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .wr_bits(wr_bits[0][16]), .wdata(bus_wdata[16]), .lock(key_b_q),
    .hw_set(1'b0), .hw_upd(1'b0), .hw_val(1'b0), .hw_live(1'b0), .q(key_a_q));

  rsb_field #(.W(1), .POL(POL_KEY), .STICKY(1'b0), .RST(1'b0)) u_key_b (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .wr_bits(wr_bits[0][24]), .wdata(bus_wdata[24]), .lock(1'b0),
    .hw_set(1'b0), .hw_upd(1'b0), .hw_val(1'b0), .hw_live(1'b0), .q(key_b_q));

  // Register 1: identity, live status, events
  rsb_field #(.W(FLD_W), .POL(POL_RO_CONST), .STICKY(1'b0), .RST(ID_VAL)) u_id (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .wr_bits(wr_bits[1][7:0]), .wdata(bus_wdata[7:0]), .lock(1'b0),
    .hw_set(ZF), .hw_upd(1'b0), .hw_val(ZF), .hw_live(ZF), .q(id_q));

  rsb_field #(.W(FLD_W), .POL(POL_RO_LIVE), .STICKY(1'b0), .RST(8'h00)) u_live (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .wr_bits(wr_bits[1][15:8]), .wdata(bus_wdata[15:8]), .lock(1'b0),
    .hw_set(ZF), .hw_upd(1'b0), .hw_val(ZF), .hw_live(hw_status), .q(live_q));

  rsb_field #(.W(FLD_W), .POL(POL_W1C), .STICKY(1'b0), .RST(8'h00)) u_evt (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .wr_bits(wr_bits[1][23:16]), .wdata(bus_wdata[23:16]), .lock(1'b0),
    .hw_set(evt_set), .hw_upd(1'b0), .hw_val(ZF), .hw_live(ZF), .q(evt_q));

  rsb_field #(.W(FLD_W), .POL(POL_W1C), .STICKY(1'b1), .RST(8'h00)) u_sevt (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .wr_bits(wr_bits[1][31:24]), .wdata(bus_wdata[31:24]), .lock(1'b0),
    .hw_set(sevt_set), .hw_upd(1'b0), .hw_val(ZF), .hw_live(ZF), .q(sevt_q));

  // Register 2: locked sticky events, volatile field, sticky key
  rsb_field #(.W(FLD_W), .POL(POL_W1C), .STICKY(1'b1), .RST(8'h00)) u_slk (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .wr_bits(wr_bits[2][7:0]), .wdata(bus_wdata[7:0]), .lock(key_a_q),
    .hw_set(slk_set), .hw_upd(1'b0), .hw_val(ZF), .hw_live(ZF), .q(slk_q));

  rsb_field #(.W(FLD_W), .POL(POL_RWV), .STICKY(1'b0), .RST(8'h00)) u_vol (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .wr_bits(wr_bits[2][15:8]), .wdata(bus_wdata[15:8]), .lock(key_s_q),
    .hw_set(ZF), .hw_upd(vol_upd), .hw_val(vol_val), .hw_live(ZF), .q(vol_q));

  rsb_field #(.W(1), .POL(POL_KEY), .STICKY(1'b1), .RST(1'b0)) u_key_s (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .wr_bits(wr_bits[2][24]), .wdata(bus_wdata[24]), .lock(1'b0),
    .hw_set(1'b0), .hw_upd(1'b0), .hw_val(1'b0), .hw_live(1'b0), .q(key_s_q));

  assign regs[0] = {7'b0, key_b_q, 7'b0, key_a_q, cfglk_q, cfg_q};
  assign regs[1] = {sevt_q, evt_q, live_q, id_q};
  assign regs[2] = {7'b0, key_s_q, 8'b0, vol_q, slk_q};

  rsb_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .warm_rst_n (warm_rst_n),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .regs       (regs),
    .bus_rdata  (bus_rdata)
  );
endmodule

// File: rtl/rsb_bank_chk.sv
module rsb_bank_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              cold_rst_n,
  input logic              warm_rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [7:0]        evt_set,
  input logic [7:0]        evt_q,
  input logic [7:0]        cfg_q,
  input logic [7:0]        cfglk_q,
  input logic              key_a_q,
  input logic              key_b_q,
  input logic              vol_upd,
  input logic [7:0]        vol_val,
  input logic [7:0]        vol_q
);
  a_r2_set_wins: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    (evt_set != 8'h00) |=> ((evt_q & $past(evt_set)) == $past(evt_set)));

  a_r4_rw_quiet: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    !bus_wr |=> $stable(cfg_q));

  a_r6_locked_field: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    key_a_q |=> $stable(cfglk_q));

  a_r7_cascade: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    (key_b_q && !key_a_q) |=> !key_a_q);

  a_r8_key_holds: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    key_a_q |=> key_a_q);

  a_r9_hw_update: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    vol_upd |=> (vol_q == $past(vol_val)));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    (bus_rd && bus_addr == ADDR_W'(3)) |=> (bus_rdata == 32'h0));

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind rsb_bank rsb_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .cold_rst_n (cold_rst_n),
  .warm_rst_n (warm_rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .evt_set    (evt_set),
  .evt_q      (evt_q),
  .cfg_q      (cfg_q),
  .cfglk_q    (cfglk_q),
  .key_a_q    (key_a_q),
  .key_b_q    (key_b_q),
  .vol_upd    (vol_upd),
  .vol_val    (vol_val),
  .vol_q      (vol_q)
);

// File: tb/rsb_bank_bench.sv
`timescale 1ns/1ps
module rsb_bank_bench;
  logic        clk = 1'b0;
  logic        cold_rst_n = 1'b0;
  logic        warm_rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  hw_status = 8'h3C;
  logic [7:0]  evt_set = '0;
  logic [7:0]  sevt_set = '0;
  logic [7:0]  slk_set = '0;
  logic        vol_upd = 1'b0;
  logic [7:0]  vol_val = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rsb_bank u_rsb_bank (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .hw_status(hw_status),
    .evt_set(evt_set), .sevt_set(sevt_set), .slk_set(slk_set),
    .vol_upd(vol_upd), .vol_val(vol_val));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic warm_pulse();
    @(negedge clk); warm_rst_n = 1'b0;
    @(negedge clk); @(negedge clk); warm_rst_n = 1'b1;
  endtask

  task automatic cold_pulse();
    @(negedge clk); cold_rst_n = 1'b0;
    @(negedge clk); @(negedge clk); cold_rst_n = 1'b1;
  endtask

  task automatic t_reset();
    rd_chk("R4 reset value reg0", 2'd0, 32'h0000005A);
    rd_chk("R1 reset reg1", 2'd1, 32'h00003CC3);
    rd_chk("R8 keys reset reg2", 2'd2, 32'h00000000);
  endtask

  task automatic t_read_timing();
    rd_chk("R11 first read", 2'd0, 32'h0000005A);
    @(negedge clk);
    bus_addr = 2'd1; bus_rd = 1'b1;
    #1 chk("R11 before edge holds", bus_rdata, 32'h0000005A);
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R11 after edge", bus_rdata, 32'h00003CC3);
    repeat (2) @(negedge clk);
    chk("R11 hold without strobe", bus_rdata, 32'h00003CC3);
  endtask

  task automatic t_ro();
    wr(2'd1, 32'h0000FFFF, 4'b0011);
    rd_chk("R1 write ignored", 2'd1, 32'h00003CC3);
    @(negedge clk); hw_status = 8'h81;
    rd_chk("R1 live value", 2'd1, 32'h000081C3);
  endtask

  task automatic t_rw_be();
    wr(2'd0, 32'h0000A733, 4'b0001);
    rd_chk("R5 lane0 only", 2'd0, 32'h00000033);
    wr(2'd0, 32'h00009900, 4'b0010);
    rd_chk("R5 lane1 only", 2'd0, 32'h00009933);
    wr(2'd0, 32'hFFFFFFFF, 4'b0000);
    rd_chk("R5 no lanes", 2'd0, 32'h00009933);
    repeat (5) @(negedge clk);
    rd_chk("R4 holds idle", 2'd0, 32'h00009933);
  endtask

  task automatic t_w1c();
    @(negedge clk); evt_set = 8'hF0;
    @(negedge clk); evt_set = 8'h00;
    rd_chk("R2 hw set", 2'd1, 32'h00F081C3);
    wr(2'd1, 32'h00300000, 4'b0100);
    rd_chk("R2 write1 clears", 2'd1, 32'h00C081C3);
    wr(2'd1, 32'h00000000, 4'b1111);
    rd_chk("R2 write0 no effect", 2'd1, 32'h00C081C3);
    @(negedge clk);
    evt_set = 8'h01; bus_addr = 2'd1; bus_wdata = 32'h00010000; bus_be = 4'b0100; bus_wr = 1'b1;
    @(negedge clk);
    evt_set = 8'h00; bus_wr = 1'b0; bus_be = '0;
    rd_chk("R2 set beats clear", 2'd1, 32'h00C181C3);
    wr(2'd1, 32'h00FF0000, 4'b0100);
    rd_chk("R2 clear all", 2'd1, 32'h000081C3);
  endtask

  task automatic t_unmapped();
    wr(2'd3, 32'hFFFFFFFF, 4'b1111);
    rd_chk("R10 unmapped read", 2'd3, 32'h00000000);
    rd_chk("R10 reg0 untouched", 2'd0, 32'h00009933);
  endtask

  task automatic t_vol();
    wr(2'd2, 32'h00007700, 4'b0010);
    rd_chk("R9 sw write", 2'd2, 32'h00007700);
    @(negedge clk); vol_upd = 1'b1; vol_val = 8'h12;
    @(negedge clk); vol_upd = 1'b0;
    rd_chk("R9 hw update", 2'd2, 32'h00001200);
    @(negedge clk);
    vol_upd = 1'b1; vol_val = 8'h99;
    bus_addr = 2'd2; bus_wdata = 32'h00005500; bus_be = 4'b0010; bus_wr = 1'b1;
    @(negedge clk);
    vol_upd = 1'b0; bus_wr = 1'b0; bus_be = '0;
    rd_chk("R9 hw wins race", 2'd2, 32'h00009900);
    wr(2'd2, 32'h01000000, 4'b1000);
    rd_chk("R8 key S set", 2'd2, 32'h01009900);
    wr(2'd2, 32'h00004400, 4'b0010);
    rd_chk("R9 locked sw ignored", 2'd2, 32'h01009900);
    @(negedge clk); vol_upd = 1'b1; vol_val = 8'h21;
    @(negedge clk); vol_upd = 1'b0;
    rd_chk("R9 locked hw applies", 2'd2, 32'h01002100);
  endtask

  task automatic t_lock();
    wr(2'd0, 32'h00000000, 4'b0100);
    rd_chk("R8 write reset value", 2'd0, 32'h00009933);
    wr(2'd0, 32'h00006600, 4'b0010);
    rd_chk("R8 not locked by 0", 2'd0, 32'h00006633);
    wr(2'd0, 32'h00010000, 4'b0100);
    rd_chk("R8 key A set", 2'd0, 32'h00016633);
    wr(2'd0, 32'h00001100, 4'b0010);
    rd_chk("R6 target locked", 2'd0, 32'h00016633);
    wr(2'd0, 32'h00000000, 4'b0100);
    rd_chk("R8 key self locked", 2'd0, 32'h00016633);
    @(negedge clk); slk_set = 8'h03;
    @(negedge clk); slk_set = 8'h00;
    wr(2'd2, 32'h000000FF, 4'b0001);
    rd_chk("R6 locked w1c ignored", 2'd2, 32'h01002103);
    @(negedge clk); slk_set = 8'h04;
    @(negedge clk); slk_set = 8'h00;
    rd_chk("R6 hw set while locked", 2'd2, 32'h01002107);
  endtask

  task automatic t_sticky();
    @(negedge clk); sevt_set = 8'hA5; evt_set = 8'h02;
    @(negedge clk); sevt_set = 8'h00; evt_set = 8'h00;
    rd_chk("R3 sticky set", 2'd1, 32'hA50281C3);
    warm_pulse();
    rd_chk("R8 warm clears key A", 2'd0, 32'h0000005A);
    rd_chk("R3 sticky survives warm", 2'd1, 32'hA50081C3);
    rd_chk("R3 reg2 after warm", 2'd2, 32'h01000007);
    wr(2'd2, 32'h00003300, 4'b0010);
    rd_chk("R8 sticky key still locks", 2'd2, 32'h01000007);
    cold_pulse();
    rd_chk("R3 cold clears reg1", 2'd1, 32'h000081C3);
    rd_chk("R3 cold clears reg2", 2'd2, 32'h00000000);
    wr(2'd2, 32'h00003300, 4'b0010);
    rd_chk("R8 unlocked after cold", 2'd2, 32'h00003300);
  endtask

  task automatic t_cascade();
    wr(2'd0, 32'h01000000, 4'b1000);
    rd_chk("R7 key B set", 2'd0, 32'h0100005A);
    wr(2'd0, 32'h00010000, 4'b0100);
    rd_chk("R7 key A write ignored", 2'd0, 32'h0100005A);
    wr(2'd0, 32'h00002200, 4'b0010);
    rd_chk("R7 target still writable", 2'd0, 32'h0100225A);
    wr(2'd0, 32'h00000000, 4'b1000);
    rd_chk("R8 key B holds", 2'd0, 32'h0100225A);
    warm_pulse();
    rd_chk("R8 warm clears key B", 2'd0, 32'h0000005A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1; warm_rst_n = 1'b1;
    t_reset();
    t_read_timing();
    t_ro();
    t_rw_be();
    t_w1c();
    t_unmapped();
    t_vol();
    t_lock();
    t_sticky();
    t_cascade();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule